// File: doc/BRIEF.md
# Batch reactor sequence controller

This block runs one two-substrate batch through a reactor, starting from an idle state. The sequence is written as a statechart and then flattened into a single Moore machine. The concurrent parts of that statechart become parallel completion flags inside one global phase. Those parts are the two substrate pumps plus the wagon return, and the agent dosing plus stirring. Every actuator output is decoded from the phase register and these flags only.

The operator start input moves the controller from idle into preparation. In preparation both substrate pumps run and the wagon moves to its left stop. Each region latches its own completion sensor. The controller moves on one clock after the last of the three regions has finished, because an event raised at one edge is seen by other transitions only at the next edge.

In the reaction phase the agitator runs for the whole phase. The dosing valve stays open until the main container reports full. The controller then drains the reactor into the wagon, drives the wagon right, and dumps it. After that it returns to idle.

Top module: `reactor_seq_ctrl`

## Requirements
- R1: While rst_ni is low, and right after it rises, phase_o is 0 (idle) and every actuator output is 0.
- R2: In idle the controller stays in idle, with all actuators off, until start_i is sampled high at a rising clock edge. In idle all sensor inputs are ignored.
- R3: In preparation (phase 1), pump1_o, pump2_o and wagon_left_o are each on until sub1_ok_i, sub2_ok_i or wagon_left_i, respectively, is sampled high during that phase. After that the output stays off, even if the sensor drops again. A sensor that is high at the edge that enters preparation does not count.
- R4: Preparation is left for reaction (phase 2) at the first edge after all three preparation regions have latched, possibly on different cycles. In the cycle before the change, all three preparation outputs are off.
- R5: In reaction, agitator_o is on for the whole phase. dose_valve_o is on until reactor_full_i is sampled high in this phase. The controller moves to drain (phase 3) at the next edge after that.
- R6: In drain, drain_valve_o is on. The controller moves to wagon-right (phase 4) at the edge where reactor_empty_i is high.
- R7: In wagon-right, wagon_right_o is on until wagon_right_i is sampled high, which moves the controller to dump (phase 5). In dump, dump_o is on until wagon_empty_i is sampled high, which moves it back to idle (phase 0).
- R8: No pump output is ever on in the same cycle as drain_valve_o. wagon_left_o and wagon_right_o are never on together.
- R9: phase_o encodes the global phase as 0 idle, 1 preparation, 2 reaction, 3 drain, 4 wagon-right, 5 dump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operator start |
| sub1_ok_i | input | 1 | First substrate measured out |
| sub2_ok_i | input | 1 | Second substrate measured out |
| wagon_left_i | input | 1 | Wagon at left stop |
| wagon_right_i | input | 1 | Wagon at right stop |
| reactor_full_i | input | 1 | Main container full |
| reactor_empty_i | input | 1 | Main container empty |
| wagon_empty_i | input | 1 | Wagon emptied |
| pump1_o | output | 1 | First substrate pump |
| pump2_o | output | 1 | Second substrate pump |
| wagon_left_o | output | 1 | Wagon motor toward left |
| dose_valve_o | output | 1 | Agent dosing valve into main container |
| agitator_o | output | 1 | Agitator motor |
| drain_valve_o | output | 1 | Reactor drain valve into wagon |
| wagon_right_o | output | 1 | Wagon motor toward right |
| dump_o | output | 1 | Wagon dump actuator |
| phase_o | output | 3 | Current global phase |

## Verification
The bench finishes the three preparation regions on separate cycles. A design that left preparation on the first or second completion would start the reaction with a pump still running. A design that skipped the one-tick event delay would reach the reaction one cycle early. The bench also raises every preparation sensor at the same edge that takes start. A design that sampled sensors while still idle would switch the pumps off at once. Further checks cover sensors pulsed high while idle, a sensor dropping after it has latched, and a reset in the middle of a drain. These catch a controller that leaves idle without start, one that lets a pump turn back on, and one that keeps the drain valve open across reset.

// File: rtl/reactor_pkg.sv
package reactor_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PREP  = 3'd1,
    PH_REACT = 3'd2,
    PH_DRAIN = 3'd3,
    PH_RIGHT = 3'd4,
    PH_DUMP  = 3'd5
  } phase_t;

  localparam int unsigned PREP_N = 3;   // pump1, pump2, wagon return
  localparam int unsigned PHASE_W = $bits(phase_t);
endpackage

// File: rtl/rsc_region.sv
// One concurrent region: latches its completion event while its parent phase is active.
module rsc_region (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic hit_i,
  output logic done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        done_o <= 1'b0;
    else if (!active_i) done_o <= 1'b0;
    else if (hit_i)     done_o <= 1'b1;
  end
endmodule

// File: rtl/rsc_outdec.sv
module rsc_outdec
  import reactor_pkg::*;
(
  input  phase_t            phase_i,
  input  logic [PREP_N-1:0] prep_done_i,
  input  logic              fill_done_i,
  output logic              pump1_o,
  output logic              pump2_o,
  output logic              wagon_left_o,
  output logic              dose_valve_o,
  output logic              agitator_o,
  output logic              drain_valve_o,
  output logic              wagon_right_o,
  output logic              dump_o
);
  logic in_prep, in_react;
  assign in_prep  = (phase_i == PH_PREP);
  assign in_react = (phase_i == PH_REACT);

  assign pump1_o       = in_prep  & ~prep_done_i[0];
  assign pump2_o       = in_prep  & ~prep_done_i[1];
  assign wagon_left_o  = in_prep  & ~prep_done_i[2];
  assign dose_valve_o  = in_react & ~fill_done_i;
  assign agitator_o    = in_react;
  assign drain_valve_o = (phase_i == PH_DRAIN);
  assign wagon_right_o = (phase_i == PH_RIGHT);
  assign dump_o        = (phase_i == PH_DUMP);
endmodule

// File: rtl/reactor_seq_ctrl.sv
module reactor_seq_ctrl
  import reactor_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               sub1_ok_i,
  input  logic               sub2_ok_i,
  input  logic               wagon_left_i,
  input  logic               wagon_right_i,
  input  logic               reactor_full_i,
  input  logic               reactor_empty_i,
  input  logic               wagon_empty_i,
  output logic               pump1_o,
  output logic               pump2_o,
  output logic               wagon_left_o,
  output logic               dose_valve_o,
  output logic               agitator_o,
  output logic               drain_valve_o,
  output logic               wagon_right_o,
  output logic               dump_o,
  output logic [PHASE_W-1:0] phase_o
);
  phase_t            phase_q, phase_d;
  logic [PREP_N-1:0] prep_hit, prep_done;
  logic              prep_act, react_act, fill_done;

  assign prep_act  = (phase_q == PH_PREP);
  assign react_act = (phase_q == PH_REACT);
  assign prep_hit  = {wagon_left_i, sub2_ok_i, sub1_ok_i};

  for (genvar g = 0; g < PREP_N; g++) begin : g_prep
    rsc_region u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (prep_act),
      .hit_i    (prep_hit[g]),
      .done_o   (prep_done[g])
    );
  end

  rsc_region u_fill (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (react_act),
    .hit_i    (reactor_full_i),
    .done_o   (fill_done)
  );

  // Composite exits use latched flags: events are seen one tick after they fire.
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (start_i)         phase_d = PH_PREP;
      PH_PREP:  if (&prep_done)      phase_d = PH_REACT;
      PH_REACT: if (fill_done)       phase_d = PH_DRAIN;
      PH_DRAIN: if (reactor_empty_i) phase_d = PH_RIGHT;
      PH_RIGHT: if (wagon_right_i)   phase_d = PH_DUMP;
      PH_DUMP:  if (wagon_empty_i)   phase_d = PH_IDLE;
      default:                       phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  rsc_outdec u_dec (
    .phase_i       (phase_q),
    .prep_done_i   (prep_done),
    .fill_done_i   (fill_done),
    .pump1_o       (pump1_o),
    .pump2_o       (pump2_o),
    .wagon_left_o  (wagon_left_o),
    .dose_valve_o  (dose_valve_o),
    .agitator_o    (agitator_o),
    .drain_valve_o (drain_valve_o),
    .wagon_right_o (wagon_right_o),
    .dump_o        (dump_o)
  );

  assign phase_o = phase_q;
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       wagon_empty_i,
  input logic       pump1_o,
  input logic       pump2_o,
  input logic       wagon_left_o,
  input logic       dose_valve_o,
  input logic       agitator_o,
  input logic       drain_valve_o,
  input logic       wagon_right_o,
  input logic       dump_o,
  input logic [2:0] phase_o
);
  logic [7:0] acts;
  assign acts = {dump_o, wagon_right_o, drain_valve_o, agitator_o,
                 dose_valve_o, wagon_left_o, pump2_o, pump1_o};

  assert_pump_vs_drain_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((pump1_o || pump2_o) && drain_valve_o));

  assert_wagon_dir_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wagon_left_o && wagon_right_o));

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd0) |-> (acts == 8'h00));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd0 && !start_i) |=> (phase_o == 3'd0));

  assert_pump1_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd1 && !pump1_o) |=> !pump1_o);

  assert_prep_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd2 && $past(phase_o) == 3'd1)
      |-> ($past(acts[2:0]) == 3'b000));

  assert_stir_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd2) |-> agitator_o);

  assert_dump_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd5 && wagon_empty_i) |=> (phase_o == 3'd0));

  always_comb begin
    if (rst_ni) assert_phase_range_R9: assert (phase_o <= 3'd5);
  end
endmodule

bind reactor_seq_ctrl rsc_checker u_chk (.*);

// File: tb/tb_reactor_seq_ctrl.sv
module tb_reactor_seq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_v = 8'h00;
  logic pump1, pump2, wl_o, dose, agit, drain, wr_o, dump;
  logic [2:0] phase;
  logic [7:0] out_v;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // in_v = {wagon_empty, reactor_empty, reactor_full, wagon_right, wagon_left, sub2, sub1, start}
  reactor_seq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .start_i(in_v[0]), .sub1_ok_i(in_v[1]), .sub2_ok_i(in_v[2]),
    .wagon_left_i(in_v[3]), .wagon_right_i(in_v[4]), .reactor_full_i(in_v[5]),
    .reactor_empty_i(in_v[6]), .wagon_empty_i(in_v[7]),
    .pump1_o(pump1), .pump2_o(pump2), .wagon_left_o(wl_o), .dose_valve_o(dose),
    .agitator_o(agit), .drain_valve_o(drain), .wagon_right_o(wr_o), .dump_o(dump),
    .phase_o(phase)
  );
  assign out_v = {dump, wr_o, drain, agit, dose, wl_o, pump2, pump1};

  // row = {inputs, expected actuators, expected phase}; outputs checked after the edge
  localparam int NROW = 21;
  localparam logic [18:0] VEC [NROW] = '{
    {8'h00, 8'h00, 3'd0},  // 0 idle R2
    {8'h01, 8'h07, 3'd1},  // 1 start
    {8'h00, 8'h07, 3'd1},  // 2
    {8'h02, 8'h06, 3'd1},  // 3 sub1 latched R3
    {8'h00, 8'h06, 3'd1},  // 4 stays latched after drop
    {8'h08, 8'h02, 3'd1},  // 5 wagon left
    {8'h04, 8'h00, 3'd1},  // 6 last region done, still prep R4
    {8'h00, 8'h18, 3'd2},  // 7 reaction next tick R4
    {8'h00, 8'h18, 3'd2},  // 8
    {8'h20, 8'h10, 3'd2},  // 9 full latched R5
    {8'h00, 8'h20, 3'd3},  // 10 drain
    {8'h40, 8'h40, 3'd4},  // 11 wagon right R6
    {8'h00, 8'h40, 3'd4},  // 12
    {8'h10, 8'h80, 3'd5},  // 13 dump R7
    {8'h80, 8'h00, 3'd0},  // 14 back to idle
    {8'h7E, 8'h00, 3'd0},  // 15 sensors ignored in idle R2
    {8'h0F, 8'h07, 3'd1},  // 16 sensors at entry edge ignored R3
    {8'h0E, 8'h00, 3'd1},  // 17 all regions at once
    {8'h00, 8'h18, 3'd2},  // 18 R4
    {8'h20, 8'h10, 3'd2},  // 19
    {8'h00, 8'h20, 3'd3}   // 20
  };

  function automatic string tag_of(int idx, logic [2:0] ph);
    if (idx == 7 || idx == 18) return "R4";
    case (ph)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [10:0] act, logic [10:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_excl();  // R8
    check("R8", {10'd0, ((pump1 | pump2) & drain) | (wl_o & wr_o)}, 11'd0);
  endtask

  initial begin
    #3;
    check("R1", {out_v, phase}, 11'd0);
    #20 @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", {out_v, phase}, 11'd0);
    // R9: phase encoding checked in every row
    for (int i = 0; i < NROW; i++) begin
      @(negedge clk) in_v = VEC[i][18:11];
      @(posedge clk); #1;
      check(tag_of(i, VEC[i][2:0]), {out_v, phase}, VEC[i][10:0]);
      check_excl();
    end
    // R1: asynchronous reset in the middle of drain
    @(negedge clk) in_v = 8'h00;
    #2 rst_n = 1'b0;
    #1 check("R1", {out_v, phase}, 11'd0);
    @(negedge clk) rst_n = 1'b1;
    // R2: idle holds without start
    repeat (5) @(negedge clk);
    check("R2", {out_v, phase}, 11'd0);
    // R2: start after reset works
    @(negedge clk) in_v = 8'h01;
    @(posedge clk); #1;
    check("R2", {out_v, phase}, {8'h07, 3'd1});
    check_excl();
    @(negedge clk) in_v = 8'h00;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule